// File: doc/BRIEF.md
# Framed Serial DAC Word Loader

This block is the digital front end of a serial-input digital-to-analog converter. A host frames each transfer by pulling an active-low frame strobe low and then shifts a 16-bit word, most significant bit first, on the falling edges of a serial clock. The block counts the bits, refuses clock edges once the word is complete, and keeps the word in a shift register. It then copies the word into the converter's holding latch, whose contents are the only thing that sets the converter code.

The copy into the latch happens in one of two ways, and the choice is made per frame. The level of a separate active-low load strobe is looked at when the frame begins. If the strobe is low, the latch takes the word as soon as the last bit arrives. If the strobe is high, the word waits in the shift register and the latch takes it on the next falling edge of the load strobe. A chain-enable input turns the block into one link of a daisy chain: the counter no longer gates the clock, and the oldest bit of the shift register is driven on a serial output so that bits pass on to the next device. All serial pins are asynchronous to the block's system clock and are brought into it through synchronizers; edges of the serial clock become single-cycle enables.

A parameter sets the latch width. With a 14-bit latch the frame stays 16 bits long, the first bit received is the latch's most significant bit, and the final two bits of the stream are expected to be zero and are dropped.

Top module: `sdac_frame_loader`

## Requirements
- R1: While reset is applied, and right after it, the latch output is all zeros, the update pulse and error pulse are low, and the serial output is low.
- R2: In standalone mode with the load strobe low at frame start, the latch takes the 16 received bits (first bit received in bit 15) after the 16th falling serial clock edge, and the update output pulses high for exactly one system clock.
- R3: In standalone mode, falling serial clock edges after the 16th in a frame are ignored: the word finally latched is made of the first 16 bits only, and the bit counter never exceeds 16.
- R4: With the load strobe high at frame start, completing the frame does not change the latch; the latch takes the held word on the next falling edge of the load strobe.
- R5: A falling edge of the load strobe changes nothing when no completed strobe-mode word is pending (frame aborted, auto-mode frame, or already consumed); the latch output changes only in a cycle where the update output is high.
- R6: The frame strobe returning high before 16 bits have arrived aborts the frame without touching the latch and clears the bit counter, so the next frame loads normally.
- R7: If a frame starts while the load strobe is still low after a falling edge of it that loaded the latch, the error output pulses for one system clock; that frame runs in automatic mode.
- R8: With chain-enable high, the serial output is bit 15 of the shift register, so each bit reappears 16 serial clock falls after it entered; with chain-enable low the serial output is held low.
- R9: With chain-enable high, the counter does not stop shifting; when the frame strobe rises after at least 16 bits, the last 16 bits received are treated as the frame's word (loaded at once in automatic mode), and nothing is loaded before that rise.
- R10: With a 14-bit latch, the latch takes bits 15 down to 2 of the 16-bit frame (the first 14 bits received).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edges |
| sync_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data, most significant bit first |
| load_n_i | input | 1 | Active-low load strobe; level at frame start picks the update mode, falling edge loads a pending word |
| chain_en_i | input | 1 | High selects daisy-chain operation |
| dac_q_o | output | LATCH_W | Converter holding latch contents |
| upd_o | output | 1 | One-cycle pulse each time the latch is written |
| sdout_o | output | 1 | Serial output to the next device in a chain |
| proto_err_o | output | 1 | One-cycle pulse on a frame started with the load strobe not yet released |

## Verification
The hardest case to reach from the ports is the protocol error: it needs a strobe-mode frame, a load strobe falling edge that actually loads the latch, and then a new frame started with that strobe still held low. The bench builds this sequence directly and then repeats the frame after releasing the strobe, to show the error does not fire once the strobe has gone high. Abort and extra-clock frames are placed in the vector table between normal frames, so that a counter left in a stale state would corrupt the next word.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Frame tracking states
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_FULL  = 2'd2
  } frame_st_e;

  // Latch update policy captured at frame start
  typedef enum logic {
    UPD_AUTO   = 1'b0,
    UPD_STROBE = 1'b1
  } upd_mode_e;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= RST_VAL;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  assign nxt_o = {sr_q[W-2:0], din_i};

  always_comb begin
    sr_d = sr_q;
    if (shift_en_i) begin
      sr_d = nxt_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q_o = sr_q;

endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned LATCH_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_nxt_i,
  input  logic                  load_cur_i,
  input  logic [FRAME_BITS-1:0] word_nxt_i,
  input  logic [FRAME_BITS-1:0] word_cur_i,
  output logic [LATCH_W-1:0]    dac_q_o,
  output logic                  upd_o
);

  logic [LATCH_W-1:0] dac_q, dac_d;
  logic               upd_q, upd_d;

  // The latch always takes the earliest-received bits of the frame
  always_comb begin
    dac_d = dac_q;
    upd_d = 1'b0;
    if (load_nxt_i) begin
      dac_d = word_nxt_i[FRAME_BITS-1 -: LATCH_W];
      upd_d = 1'b1;
    end else if (load_cur_i) begin
      dac_d = word_cur_i[FRAME_BITS-1 -: LATCH_W];
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
      upd_q <= 1'b0;
    end else begin
      dac_q <= dac_d;
      upd_q <= upd_d;
    end
  end

  assign dac_q_o = dac_q;
  assign upd_o   = upd_q;

endmodule

// File: rtl/sdac_frame_ctrl.sv
module sdac_frame_ctrl
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s_i,
  input  logic             sync_n_s_i,
  input  logic             load_n_s_i,
  input  logic             chain_en_i,
  output logic             shift_en_o,
  output logic             load_nxt_o,
  output logic             load_cur_o,
  output logic             proto_err_o,
  output logic [CNT_W-1:0] bit_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic             sclk_q, sync_q, load_q;
  frame_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  upd_mode_e        mode_q, mode_d;
  logic             pend_q, pend_d;
  logic             held_q, held_d;
  logic             err_q, err_d;

  logic sclk_fall, sync_fall, sync_rise, load_fall, load_rise;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign sync_fall = sync_q & ~sync_n_s_i;
  assign sync_rise = ~sync_q & sync_n_s_i;
  assign load_fall = load_q & ~load_n_s_i;
  assign load_rise = ~load_q & load_n_s_i;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    mode_d     = mode_q;
    pend_d     = pend_q;
    held_d     = held_q;
    err_d      = 1'b0;
    shift_en_o = 1'b0;
    load_nxt_o = 1'b0;
    load_cur_o = 1'b0;

    if (load_rise) begin
      held_d = 1'b0;
    end

    unique case (state_q)
      FR_IDLE: begin
        if (sync_fall) begin
          state_d = FR_SHIFT;
          cnt_d   = '0;
          mode_d  = load_n_s_i ? UPD_STROBE : UPD_AUTO;
          pend_d  = 1'b0;
          err_d   = ~load_n_s_i & held_q;
        end
      end
      FR_SHIFT: begin
        if (sync_rise) begin
          state_d = FR_IDLE;
          cnt_d   = '0;
          if (chain_en_i && (cnt_q == CNT_FULL)) begin
            if (mode_q == UPD_AUTO) begin
              load_cur_o = 1'b1;
            end else begin
              pend_d = 1'b1;
            end
          end
        end else if (sclk_fall) begin
          shift_en_o = 1'b1;
          if (cnt_q != CNT_FULL) begin
            cnt_d = cnt_q + 1'b1;
          end
          if (!chain_en_i && (cnt_q == CNT_LAST)) begin
            state_d = FR_FULL;
            if (mode_q == UPD_AUTO) begin
              load_nxt_o = 1'b1;
            end else begin
              pend_d = 1'b1;
            end
          end
        end
      end
      FR_FULL: begin
        if (sync_rise) begin
          state_d = FR_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = FR_IDLE;
        cnt_d   = '0;
      end
    endcase

    // Strobe-triggered load of a completed, still pending word
    if (load_fall && pend_q && (state_q != FR_SHIFT) &&
        !((state_q == FR_IDLE) && sync_fall)) begin
      load_cur_o = 1'b1;
      pend_d     = 1'b0;
      held_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      load_q  <= 1'b1;
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      mode_q  <= UPD_AUTO;
      pend_q  <= 1'b0;
      held_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk_s_i;
      sync_q  <= sync_n_s_i;
      load_q  <= load_n_s_i;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      held_q  <= held_d;
      err_q   <= err_d;
    end
  end

  assign proto_err_o = err_q;
  assign bit_cnt_o   = cnt_q;

endmodule

// File: rtl/sdac_frame_loader.sv
module sdac_frame_loader #(
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned LATCH_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               sync_n_i,
  input  logic               sdin_i,
  input  logic               load_n_i,
  input  logic               chain_en_i,
  output logic [LATCH_W-1:0] dac_q_o,
  output logic               upd_o,
  output logic               sdout_o,
  output logic               proto_err_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe_q[1];

  // Pin synchronizers: {sclk, sync_n, load_n, sdin}
  logic [3:0] pins_s;

  sdac_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1110)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({sclk_i, sync_n_i, load_n_i, sdin_i}),
    .q_o   (pins_s)
  );

  logic             shift_en, load_nxt, load_cur;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_BITS-1:0] sr_q, sr_nxt;

  sdac_frame_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sclk_s_i    (pins_s[3]),
    .sync_n_s_i  (pins_s[2]),
    .load_n_s_i  (pins_s[1]),
    .chain_en_i  (chain_en_i),
    .shift_en_o  (shift_en),
    .load_nxt_o  (load_nxt),
    .load_cur_o  (load_cur),
    .proto_err_o (proto_err_o),
    .bit_cnt_o   (bit_cnt)
  );

  sdac_shift #(
    .W (FRAME_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .shift_en_i (shift_en),
    .din_i      (pins_s[0]),
    .q_o        (sr_q),
    .nxt_o      (sr_nxt)
  );

  sdac_latch #(
    .FRAME_BITS (FRAME_BITS),
    .LATCH_W    (LATCH_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_nxt_i (load_nxt),
    .load_cur_i (load_cur),
    .word_nxt_i (sr_nxt),
    .word_cur_i (sr_q),
    .dac_q_o    (dac_q_o),
    .upd_o      (upd_o)
  );

  assign sdout_o = chain_en_i & sr_q[FRAME_BITS-1];

endmodule

// File: rtl/sdac_frame_loader_chk.sv
module sdac_frame_loader_chk #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned LATCH_W    = 16,
  parameter int unsigned CNT_W      = 5
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               chain_en_i,
  input logic               sdout_o,
  input logic               upd_o,
  input logic               proto_err_o,
  input logic [LATCH_W-1:0] dac_q_o,
  input logic [CNT_W-1:0]   bit_cnt
);

  // R1: outputs cleared while the internal reset is held
  always @(posedge clk) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (dac_q_o == '0 && !upd_o && !proto_err_o);
    end
  end

  // R2: update pulse lasts one cycle
  p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  // R3: counter never passes the frame length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_BITS));

  // R5: latch only moves together with the update pulse
  p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !upd_o |-> $stable(dac_q_o));

  // R7: error is a single-cycle pulse
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    proto_err_o |=> !proto_err_o);

  // R8: serial output idle outside chain operation
  p_sdout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !chain_en_i |-> !sdout_o);

endmodule

bind sdac_frame_loader sdac_frame_loader_chk #(
  .FRAME_BITS (FRAME_BITS),
  .LATCH_W    (LATCH_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_n_int),
  .chain_en_i  (chain_en_i),
  .sdout_o     (sdout_o),
  .upd_o       (upd_o),
  .proto_err_o (proto_err_o),
  .dac_q_o     (dac_q_o),
  .bit_cnt     (bit_cnt)
);

// File: tb/test_sdac_frame_loader.sv
module test_sdac_frame_loader;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sclk, sync_n, sdin, load_n, chain_en;
  logic [15:0] dac;
  logic [13:0] dac_n;
  logic upd, sdout, err, upd_n, sdout_n, err_n;

  sdac_frame_loader i_sdac_frame_loader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
    .load_n_i(load_n), .chain_en_i(chain_en), .dac_q_o(dac), .upd_o(upd),
    .sdout_o(sdout), .proto_err_o(err)
  );

  // Narrow-latch instance for R10
  sdac_frame_loader #(.LATCH_W(14)) i_narrow (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
    .load_n_i(load_n), .chain_en_i(chain_en), .dac_q_o(dac_n), .upd_o(upd_n),
    .sdout_o(sdout_n), .proto_err_o(err_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int err_seen = 0;
  int upd_seen = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (err) err_seen++;
    if (upd) upd_seen++;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin = b;
    wait_clk(3);
    sclk = 1'b0;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(3);
  endtask

  task automatic frame(input logic [15:0] word, input int nbits);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      send_bit(i < 16 ? word[15-i] : 1'b1);
    end
    sync_n = 1'b1;
    wait_clk(8);
  endtask

  typedef struct packed {
    logic        auto_m;
    logic [5:0]  nbits;
    logic        strobe_after;
    logic [15:0] word;
    logic [15:0] exp_end;
    logic [15:0] exp_fin;
  } vec_t;

  // auto_m=1: load strobe low at frame start (automatic update)
  localparam vec_t VEC [8] = '{
    '{1'b1, 6'd16, 1'b0, 16'hA5C3, 16'hA5C3, 16'hA5C3},  // R2
    '{1'b0, 6'd16, 1'b1, 16'hBEEF, 16'hA5C3, 16'hBEEF},  // R4
    '{1'b0, 6'd20, 1'b1, 16'h0F0F, 16'hBEEF, 16'h0F0F},  // R3 extra edges
    '{1'b1, 6'd9,  1'b0, 16'hFFFF, 16'h0F0F, 16'h0F0F},  // R6 abort
    '{1'b1, 6'd16, 1'b0, 16'h8001, 16'h8001, 16'h8001},  // R6 recovery
    '{1'b1, 6'd16, 1'b0, 16'h0000, 16'h0000, 16'h0000},  // R2
    '{1'b0, 6'd10, 1'b1, 16'h7777, 16'h0000, 16'h0000},  // R5 no pending word
    '{1'b1, 6'd16, 1'b0, 16'hFFFC, 16'hFFFC, 16'hFFFC}   // R10 trailing zeros
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    int e0, u0;
    rst_n = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0; load_n = 1'b1; chain_en = 1'b0;
    wait_clk(5);
    // R1: reset state
    check("R1 dac during reset", 32'(dac), 32'h0);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 dac after reset", 32'(dac), 32'h0);
    check("R1 upd after reset", 32'(upd), 32'h0);
    check("R1 err after reset", 32'(err), 32'h0);
    check("R8 sdout standalone", 32'(sdout), 32'h0);

    for (int v = 0; v < 8; v++) begin
      u0 = upd_seen;
      load_n = VEC[v].auto_m ? 1'b0 : 1'b1;
      wait_clk(4);
      frame(VEC[v].word, int'(VEC[v].nbits));
      check($sformatf("vec%0d end (R2 R3 R4 R6)", v), 32'(dac), 32'(VEC[v].exp_end));
      check($sformatf("vec%0d narrow (R10)", v), 32'(dac_n), 32'(VEC[v].exp_end[15:2]));
      if (VEC[v].auto_m && VEC[v].nbits == 6'd16)
        check($sformatf("vec%0d one update pulse (R2)", v), 32'(upd_seen - u0), 32'd1);
      if (VEC[v].strobe_after) begin
        load_n = 1'b0;
        wait_clk(8);
        check($sformatf("vec%0d strobe load (R4 R5)", v), 32'(dac), 32'(VEC[v].exp_fin));
      end
      load_n = 1'b1;
      wait_clk(6);
    end

    // R7: frame started while strobe still low after a strobe load
    load_n = 1'b1;
    wait_clk(4);
    frame(16'h3C3C, 16);
    load_n = 1'b0;
    wait_clk(8);
    check("R4 strobe load before error case", 32'(dac), 32'h3C3C);
    e0 = err_seen;
    frame(16'h5A5A, 16);
    check("R7 error pulse count", 32'(err_seen - e0), 32'd1);
    check("R7 frame ran automatic", 32'(dac), 32'h5A5A);
    load_n = 1'b1;
    wait_clk(6);
    load_n = 1'b0;
    wait_clk(4);
    e0 = err_seen;
    frame(16'h1111, 16);
    check("R7 no error after release", 32'(err_seen - e0), 32'd0);
    check("R7 auto frame after release", 32'(dac), 32'h1111);
    load_n = 1'b1;
    wait_clk(6);

    // R8 / R9: chain operation, 32 bits in one frame
    chain_en = 1'b1;
    load_n = 1'b0;
    wait_clk(4);
    sync_n = 1'b0;
    wait_clk(4);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= 16) got[31-i] = sdout;
      send_bit(i < 16 ? 16'hC0DE >> (15 - i) : 16'h4B2D >> (31 - i));
    end
    check("R9 no load before frame end", 32'(dac), 32'h1111);
    sync_n = 1'b1;
    wait_clk(8);
    check("R8 chained bits on sdout", 32'(got), 32'hC0DE);
    check("R9 last word latched at frame end", 32'(dac), 32'h4B2D);
    chain_en = 1'b0;
    load_n = 1'b1;
    wait_clk(4);
    check("R8 sdout low when chain off", 32'(sdout), 32'h0);

    // R1: reset in the middle of a frame
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    rst_n = 1'b0;
    wait_clk(3);
    check("R1 dac cleared by reset", 32'(dac), 32'h0);
    sync_n = 1'b1;
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 err low after reset", 32'(err), 32'h0);

    finish_run();
  end

endmodule